// File: doc/BRIEF.md
# Parallel Fork-Join Thread Controller

This block launches a group of child sequencers together and reports completion of the whole group once every child has finished. A single pulse or level on the top-level start input moves the controller from idle into a running phase. In that phase each child sees a start request. Each child later returns a done indication, which may come in the same cycle as its start or many cycles later.

Every child has its own sticky one-bit completion flag. The flag records that the child has reported done and keeps that child's start request low for the rest of the invocation, so a child that finishes early is never launched again while its siblings are still busy. A three-state join machine watches the AND of all flags. When the AND is true it spends exactly one cycle in a done state, raising the top-level done output, and then returns to idle. All flags are cleared on that return, so the next invocation waits for fresh completions.

The number of children is a parameter. The fold that forms the join starts from a constant true.

Top module: `fj_fork_join_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in idle and clears every completion flag: done_o and all thr_start_o bits are low in the cycle after reset, and a following invocation launches every child afresh.
- R2: In idle the controller stays idle while start_i is low (done_o and thr_start_o stay low). When start_i is sampled high it enters the running state at that clock edge.
- R3: While running, thr_start_o[i] is high exactly when child i's completion flag is clear and thr_done_i[i] is low.
- R4: A high thr_done_i[i] in the running state sets child i's flag. Once the flag is set, child i's start stays low for the rest of the invocation, so each child sees exactly one start request per invocation.
- R5: The controller enters the done state at the first clock edge at which every flag is already set. If the start edge is counted as edge 0 and the slowest child raises done L cycles after its launch cycle, done_o goes high after edge L+2.
- R6: done_o is high for exactly one cycle per invocation, and the controller then returns to idle unconditionally.
- R7: thr_start_o is all low in the idle and done states. thr_done_i seen in the idle state has no effect on any flag.
- R8: Every flag is cleared when the controller leaves the done state, and thr_done_i seen during the done state has no effect. A second invocation therefore waits for fresh completions from every child.
- R9: A child that raises done in its own launch cycle (zero latency) is accepted and recorded like any other completion.
- R10: The wrapping overhead is fixed: a child doing one cycle of work (done one cycle after launch) produces done_o three edges after the start edge, with no dependence on how many children there are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch request for the whole group, sampled in idle |
| done_o | output | 1 | One-cycle pulse: every child has completed |
| thr_start_o | output | NUM_THREADS | Per-child start request |
| thr_done_i | input | NUM_THREADS | Per-child completion indication |

## Verification
The bench builds the controller with NUM_THREADS set to 4. Each of the four children is modelled as a unit whose latency the bench sets for each invocation. Four children are enough to mix zero-latency finishers, equal latencies, and a single straggler in one invocation. With that mix the bench can watch early finishers held idle while the straggler runs, and can check the join timing against the largest latency. Stray done indications are injected in the idle and done states, and a reset is applied while one child has already latched completion, so the clearing of the flags can be seen at the ports.

// File: rtl/fj_pkg.sv
package fj_pkg;

  // Join machine states; the encoding is observable through the checker.
  typedef enum logic [1:0] {
    FJ_IDLE = 2'd0,
    FJ_RUN  = 2'd1,
    FJ_DONE = 2'd2
  } fj_state_e;

  // Next-state rule of the join machine.
  function automatic fj_state_e fj_step(input fj_state_e cur,
                                        input logic go,
                                        input logic joined);
    fj_state_e nxt;
    unique case (cur)
      FJ_IDLE: nxt = go ? FJ_RUN : FJ_IDLE;
      FJ_RUN:  nxt = joined ? FJ_DONE : FJ_RUN;
      FJ_DONE: nxt = FJ_IDLE;
      default: nxt = FJ_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/fj_done_latch.sv
// One sticky completion flag. Single write driver: clear has priority.
module fj_done_latch (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic set_i,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      flag_o <= 1'b0;
    end else if (set_i) begin
      flag_o <= 1'b1;
    end
  end

endmodule

// File: rtl/fj_launch_gate.sv
// Per-child start gating: only while running, flag clear, done low.
module fj_launch_gate #(
  parameter int NUM_THREADS = 4
) (
  input  logic                   run_i,
  input  logic [NUM_THREADS-1:0] flag_i,
  input  logic [NUM_THREADS-1:0] done_i,
  output logic [NUM_THREADS-1:0] start_o
);

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_gate
    assign start_o[g] = run_i & ~flag_i[g] & ~done_i[g];
  end

endmodule

// File: rtl/fj_join_fsm.sv
// Three-state join machine with an AND-fold over the completion flags.
module fj_join_fsm #(
  parameter int NUM_THREADS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   go_i,
  input  logic [NUM_THREADS-1:0] flag_i,
  output fj_pkg::fj_state_e      state_o,
  output logic                   joined_o,
  output logic                   run_o,
  output logic                   leave_o,
  output logic                   done_o
);

  import fj_pkg::*;

  // Fold from constant true: an empty group joins at once.
  function automatic logic all_joined(input logic [NUM_THREADS-1:0] v);
    logic acc;
    acc = 1'b1;
    for (int i = 0; i < NUM_THREADS; i++) begin
      acc = acc & v[i];
    end
    return acc;
  endfunction

  fj_state_e state_q;

  assign joined_o = all_joined(flag_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FJ_IDLE;
    end else begin
      state_q <= fj_step(state_q, go_i, joined_o);
    end
  end

  assign state_o = state_q;
  assign run_o   = (state_q == FJ_RUN);
  assign leave_o = (state_q == FJ_DONE);
  assign done_o  = (state_q == FJ_DONE);

endmodule

// File: rtl/fj_fork_join_ctrl.sv
module fj_fork_join_ctrl #(
  parameter int NUM_THREADS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  output logic                   done_o,
  output logic [NUM_THREADS-1:0] thr_start_o,
  input  logic [NUM_THREADS-1:0] thr_done_i
);

  // Named internal events, visible to the bound checker.
  fj_pkg::fj_state_e      fsm_state;
  logic                   join_w;
  logic                   run_w;
  logic                   leave_w;
  logic [NUM_THREADS-1:0] set_w;
  logic [NUM_THREADS-1:0] latch_q;

  fj_join_fsm #(.NUM_THREADS(NUM_THREADS)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .go_i     (start_i),
    .flag_i   (latch_q),
    .state_o  (fsm_state),
    .joined_o (join_w),
    .run_o    (run_w),
    .leave_o  (leave_w),
    .done_o   (done_o)
  );

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    assign set_w[g] = run_w & thr_done_i[g];
    fj_done_latch u_latch (
      .clk     (clk),
      .rst     (rst),
      .clear_i (leave_w),
      .set_i   (set_w[g]),
      .flag_o  (latch_q[g])
    );
  end

  fj_launch_gate #(.NUM_THREADS(NUM_THREADS)) u_gate (
    .run_i   (run_w),
    .flag_i  (latch_q),
    .done_i  (thr_done_i),
    .start_o (thr_start_o)
  );

endmodule

// File: rtl/fj_fork_join_chk.sv
module fj_fork_join_chk #(
  parameter int NUM_THREADS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   start_i,
  input logic                   done_o,
  input logic [NUM_THREADS-1:0] thr_start_o,
  input logic [NUM_THREADS-1:0] latch_q,
  input fj_pkg::fj_state_e      fsm_state,
  input logic                   join_w
);

  import fj_pkg::*;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (fsm_state == FJ_IDLE && latch_q == '0 && !done_o));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == FJ_IDLE && !start_i) |=> (fsm_state == FJ_IDLE));

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (fsm_state != FJ_DONE) |=> ((latch_q & $past(latch_q)) == $past(latch_q)));

  assert_join_before_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(join_w));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_quiet_in_done_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (thr_start_o == '0));

  assert_flags_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == FJ_DONE) |=> (latch_q == '0));

endmodule

bind fj_fork_join_ctrl fj_fork_join_chk #(.NUM_THREADS(NUM_THREADS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .done_o      (done_o),
  .thr_start_o (thr_start_o),
  .latch_q     (latch_q),
  .fsm_state   (fsm_state),
  .join_w      (join_w)
);

// File: tb/tb_fj_fork_join_ctrl.sv
module tb_fj_fork_join_ctrl;

  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          done_o;
  logic [NT-1:0] thr_start_o;
  logic [NT-1:0] thr_done_i;
  logic [NT-1:0] mdl_done = '0;
  logic [NT-1:0] inj_done = '0;

  assign thr_done_i = mdl_done | inj_done;

  always #2 clk = ~clk;

  fj_fork_join_ctrl #(.NUM_THREADS(NT)) dut (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .done_o      (done_o),
    .thr_start_o (thr_start_o),
    .thr_done_i  (thr_done_i)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Child model state (written only by the model process).
  int            lat[NT];
  bit            busy[NT];
  int            cnt[NT];
  int            n_start[NT];
  int            n_done[NT];
  logic [NT-1:0] prev_start = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Variable-latency children: launch on start, done L cycles later.
  always @(negedge clk) begin
    for (int i = 0; i < NT; i++) begin
      if (rst) begin
        busy[i] = 0;
        cnt[i] = 0;
        mdl_done[i] = 1'b0;
        prev_start[i] = 1'b0;
      end else begin
        bit nd;
        nd = 0;
        if (thr_start_o[i] && !prev_start[i]) n_start[i]++;
        prev_start[i] = thr_start_o[i];
        if (busy[i]) begin
          cnt[i]--;
          if (cnt[i] <= 0) begin
            nd = 1;
            busy[i] = 0;
          end
        end else if (thr_start_o[i] && !mdl_done[i]) begin
          if (lat[i] == 0) nd = 1;
          else begin
            busy[i] = 1;
            cnt[i] = lat[i];
          end
        end
        mdl_done[i] = nd;
        if (nd) n_done[i]++;
      end
    end
  end

  // One invocation with given latencies; checks R3 R4 R5 R6 R7 (and R8 stray done).
  task automatic run_inv(input int l0, input int l1, input int l2, input int l3,
                         input bit inj_at_done, input string tag);
    int bs[NT];
    int bd[NT];
    int maxl;
    int k;
    bit r3_bad;
    lat[0] = l0; lat[1] = l1; lat[2] = l2; lat[3] = l3;
    maxl = 0;
    for (int i = 0; i < NT; i++) begin
      if (lat[i] > maxl) maxl = lat[i];
      bs[i] = n_start[i];
      bd[i] = n_done[i];
    end
    r3_bad = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    k = 0;
    while (1) begin
      @(posedge clk);
      #1;
      k++;
      if (done_o || k > maxl + 20) break;
      for (int i = 0; i < NT; i++) begin
        if (thr_start_o[i] != (n_done[i] == bd[i])) r3_bad = 1;
      end
    end
    check(!r3_bad, "R3", {tag, " start gating while running"}, r3_bad, 0);
    check(k == maxl + 2, "R5", {tag, " edges from start to done"}, k, maxl + 2);
    check(thr_start_o == '0, "R7", {tag, " starts low in done state"},
          int'(thr_start_o), 0);
    for (int i = 0; i < NT; i++) begin
      check(n_start[i] - bs[i] == 1, "R4", {tag, " one start per child"},
            n_start[i] - bs[i], 1);
      check(n_done[i] - bd[i] == 1, "R4", {tag, " one done per child"},
            n_done[i] - bd[i], 1);
    end
    if (inj_at_done) inj_done = '1;
    @(posedge clk);
    #1;
    inj_done = '0;
    check(!done_o, "R6", {tag, " done lasts one cycle"}, int'(done_o), 0);
  endtask

  task automatic test_reset_state();
    repeat (3) @(posedge clk);
    #1;
    check(!done_o, "R1", "done low in reset", int'(done_o), 0);
    check(thr_start_o == '0, "R1", "starts low in reset", int'(thr_start_o), 0);
    rst = 1'b0;
  endtask

  task automatic test_idle_hold();
    bit bad;
    bad = 0;
    inj_done = '1;
    for (int c = 0; c < 6; c++) begin
      @(posedge clk);
      #1;
      if (c == 2) inj_done = '0;
      if (done_o || thr_start_o != '0) bad = 1;
    end
    check(!bad, "R2", "idle holds without start", bad, 0);
    // Stray dones in idle must not pre-set any flag (R7).
    run_inv(2, 2, 2, 2, 0, "R7 after idle stray done");
  endtask

  task automatic test_mixed();
    run_inv(0, 3, 1, 5, 0, "R5 mixed");
    run_inv(0, 0, 0, 0, 0, "R9 all zero latency");
    run_inv(4, 4, 4, 4, 0, "R5 equal");
    run_inv(0, 0, 0, 9, 0, "R4 straggler");
  endtask

  task automatic test_back_to_back();
    run_inv(2, 1, 3, 0, 1, "R8 first with stray done");
    run_inv(3, 3, 1, 2, 0, "R8 second needs fresh dones");
  endtask

  task automatic test_overhead();
    int t0;
    int t1;
    lat[0] = 1; lat[1] = 1; lat[2] = 1; lat[3] = 1;
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    t0 = $time;
    #1 start_i = 1'b0;
    while (!done_o) begin
      @(posedge clk);
      #1;
      if ($time - t0 > 400) break;
    end
    t1 = ($time - 1 - t0) / 4;
    $display("overhead: one-cycle children -> done after %0d edges", t1);
    check(t1 == 3, "R10", "one-cycle child overhead", t1, 3);
    @(posedge clk);
    #1;
  endtask

  task automatic test_reset_mid_run();
    lat[0] = 0; lat[1] = 6; lat[2] = 6; lat[3] = 6;
    @(negedge clk);
    start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b1;
    @(posedge clk);
    #1;
    check(!done_o, "R1", "done low after mid-run reset", int'(done_o), 0);
    check(thr_start_o == '0, "R1", "starts low after mid-run reset",
          int'(thr_start_o), 0);
    rst = 1'b0;
    run_inv(3, 1, 1, 1, 0, "R1 flags cleared by reset");
  endtask

  initial begin
    for (int i = 0; i < NT; i++) begin
      lat[i] = 0;
      n_start[i] = 0;
      n_done[i] = 0;
    end
    test_reset_state();
    test_idle_hold();
    test_mixed();
    test_back_to_back();
    test_overhead();
    test_reset_mid_run();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule